// File: doc/BRIEF.md
# Fractional DCO Word Calculator

This block turns a requested oscillator frequency, given in whole MHz, and a reference clock frequency, given in kHz, into the setting of a fractional frequency multiplier. The multiplier value is an integer part plus a 15-bit fraction over 2^15. The block packs both parts into one configuration word that a PLL control path can write unchanged. The fraction is rounded toward the higher value rather than truncated. A reference of exactly 38400 kHz is treated as 19200 kHz, because that source is divided by two before it reaches the multiplier.

A one-cycle start strobe captures both operands. The block forms the dividend `dco * 1000 * 2^15`. A 40-step restoring divider then divides it by the reference and produces one quotient bit per cycle, so no hard divider is needed. Adding one whenever the remainder is nonzero gives the rounded-up quotient. The integer field and the fraction field are both cut from that single quotient, so a fraction that rounds up to 2^15 carries into the integer part without any extra logic. The controller has five named states:

- `ST_IDLE`: waits for start and captures the operands.
- `ST_LOAD`: seeds the divider.
- `ST_DIVIDE`: runs one quotient bit per cycle.
- `ST_ROUND`: rounds the quotient and registers the results.
- `ST_FINISH`: raises done for one cycle.

The transitions are:

- `ST_IDLE` to `ST_LOAD` on start.
- `ST_LOAD` to `ST_DIVIDE` always.
- `ST_DIVIDE` to `ST_ROUND` after the last quotient bit.
- `ST_ROUND` to `ST_FINISH` always.
- `ST_FINISH` to `ST_IDLE` always.

Top module: `dco_word_calc`

## Requirements
- R1: After reset, `done_o` is 0, and `int_o`, `frac_o` and `word_o` are all zero.
- R2: Let Q be the ceiling of `dco_mhz_i * 1000 * 32768 / r`, where r is the effective reference. The integer result is bits [24:15] of Q, which is the low 10 bits of Q >> 15. Any higher integer bits are dropped.
- R3: The fraction result is bits [14:0] of that same Q. When the division is exact, no rounding is applied.
- R4: When the rounded-up fraction reaches 2^15, the fraction becomes 0 and the integer part is one higher than the truncated value.
- R5: A reference input of exactly 38400 is replaced by 19200 before the division. Every other value, 38401 for example, is used unchanged.
- R6: `word_o[9:0]` equals the integer result and `word_o[24:10]` equals the fraction result.
- R7: `done_o` rises exactly 42 clock edges after the edge that accepts start, and stays high for exactly one cycle.
- R8: The operands are captured on the edge that accepts start. Changes to the operand inputs after that edge have no effect on the result. A start strobe that arrives while a computation is running is ignored and does not begin another computation.
- R9: A reference of zero gives an integer result of all ones (1023) and a fraction of all ones (32767).
- R10: Between completions, `int_o`, `frac_o` and `word_o` hold their last values, whatever happens on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request; accepted only when idle |
| dco_mhz_i | input | 15 | Target oscillator frequency in MHz |
| ref_khz_i | input | 17 | Reference clock frequency in kHz |
| done_o | output | 1 | One-cycle pulse when new results are valid |
| int_o | output | 10 | Integer part of the multiplier |
| frac_o | output | 15 | Fraction of the multiplier, in units of 2^-15 |
| word_o | output | 25 | Packed word: fraction in [24:10], integer in [9:0] |

## Verification
Every result of this block is due at one moment: 42 edges after the accepting edge, in the cycle where `done_o` is high. The values then hold until the next completion. Each scenario task counts edges from the accepting edge, sampling 1 ns after each edge, and then checks that the count is exactly 42. It reads the integer, fraction and packed word in that done cycle and checks that `done_o` is low again one edge later. A separate checker uses a cycle counter to confirm the same 42-edge distance, so the 40-step window is not unrolled into a long delay.

// File: rtl/dco_calc_pkg.sv
package dco_calc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD   = 3'd1,
        ST_DIVIDE = 3'd2,
        ST_ROUND  = 3'd3,
        ST_FINISH = 3'd4
    } calc_state_e;

    // Bits needed to hold the kHz-per-MHz scale factor.
    localparam int unsigned SCALE_KHZ = 1000;
    localparam int unsigned SCALE_W   = $clog2(SCALE_KHZ);

endpackage

// File: rtl/dco_ref_normalize.sv
// Maps the one reference value whose source is pre-divided onto its halved value.
module dco_ref_normalize #(
    parameter int unsigned REF_W     = 17,
    parameter int unsigned HALVE_KHZ = 38400
) (
    input  logic [REF_W-1:0] ref_raw_i,
    output logic [REF_W-1:0] ref_eff_o,
    output logic             ref_zero_o
);
    localparam logic [REF_W-1:0] HALVE_VAL = REF_W'(HALVE_KHZ);

    always_comb begin
        if (ref_raw_i == HALVE_VAL) begin
            ref_eff_o = {1'b0, ref_raw_i[REF_W-1:1]};
        end else begin
            ref_eff_o = ref_raw_i;
        end
        ref_zero_o = (ref_raw_i == '0);
    end

endmodule

// File: rtl/dco_restoring_div.sv
// Iterative restoring divider: one quotient bit per step, MSB first.
module dco_restoring_div #(
    parameter int unsigned DVD_W = 40,
    parameter int unsigned DVS_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic [DVD_W-1:0] quot_o,
    output logic [DVS_W-1:0] rem_o,
    output logic             last_o
);
    localparam int unsigned CNT_W = $clog2(DVD_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DVD_W - 1);

    logic [DVD_W-1:0] shq_q;
    logic [DVS_W-1:0] acc_q;
    logic [DVS_W-1:0] dvs_q;
    logic [CNT_W-1:0] cnt_q;

    logic [DVS_W:0]   trial;
    logic [DVS_W:0]   diff;
    logic             fits;

    always_comb begin
        trial = {acc_q, shq_q[DVD_W-1]};
        fits  = (trial >= {1'b0, dvs_q});
        diff  = trial - {1'b0, dvs_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shq_q <= '0;
            acc_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            shq_q <= dividend_i;
            acc_q <= '0;
            dvs_q <= divisor_i;
            cnt_q <= '0;
        end else if (step_i) begin
            shq_q <= {shq_q[DVD_W-2:0], fits};
            acc_q <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign quot_o = shq_q;
    assign rem_o  = acc_q;
    assign last_o = (cnt_q == LAST_CNT);

endmodule

// File: rtl/dco_round_pack.sv
// Rounds the quotient upward on a nonzero remainder and splits it into fields.
module dco_round_pack #(
    parameter int unsigned DVD_W  = 40,
    parameter int unsigned DVS_W  = 17,
    parameter int unsigned INT_W  = 10,
    parameter int unsigned FRAC_W = 15
) (
    input  logic [DVD_W-1:0]        quot_i,
    input  logic [DVS_W-1:0]        rem_i,
    input  logic                    div_zero_i,
    output logic [INT_W-1:0]        int_o,
    output logic [FRAC_W-1:0]       frac_o,
    output logic [INT_W+FRAC_W-1:0] word_o
);
    logic [DVD_W-1:0] rounded;
    logic             bump;

    always_comb begin
        bump    = (rem_i != '0);
        rounded = quot_i + DVD_W'(bump);
        if (div_zero_i) begin
            int_o  = '1;
            frac_o = '1;
        end else begin
            int_o  = rounded[FRAC_W +: INT_W];
            frac_o = rounded[FRAC_W-1:0];
        end
        word_o = {frac_o, int_o};
    end

endmodule

// File: rtl/dco_word_calc.sv
module dco_word_calc
    import dco_calc_pkg::*;
#(
    parameter int unsigned DCO_W     = 15,
    parameter int unsigned REF_W     = 17,
    parameter int unsigned INT_W     = 10,
    parameter int unsigned FRAC_W    = 15,
    parameter int unsigned HALVE_KHZ = 38400
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [DCO_W-1:0]        dco_mhz_i,
    input  logic [REF_W-1:0]        ref_khz_i,
    output logic                    done_o,
    output logic [INT_W-1:0]        int_o,
    output logic [FRAC_W-1:0]       frac_o,
    output logic [INT_W+FRAC_W-1:0] word_o
);
    localparam int unsigned NUM_W  = DCO_W + SCALE_W;
    localparam int unsigned DVD_W  = NUM_W + FRAC_W;
    localparam int unsigned WORD_W = INT_W + FRAC_W;

    calc_state_e state_q, state_d;

    logic [DCO_W-1:0]  dco_q;
    logic [REF_W-1:0]  ref_q;
    logic              ref_zero_q;
    logic [REF_W-1:0]  ref_eff;
    logic              ref_zero;

    logic [NUM_W-1:0]  num_khz;
    logic [DVD_W-1:0]  dividend;
    logic [DVD_W-1:0]  quot;
    logic [REF_W-1:0]  rem;
    logic              div_last;
    logic              div_load;
    logic              div_step;

    logic [INT_W-1:0]  int_n;
    logic [FRAC_W-1:0] frac_n;
    logic [WORD_W-1:0] word_n;

    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    logic [WORD_W-1:0] word_q;

    dco_ref_normalize #(
        .REF_W     (REF_W),
        .HALVE_KHZ (HALVE_KHZ)
    ) u_norm (
        .ref_raw_i  (ref_khz_i),
        .ref_eff_o  (ref_eff),
        .ref_zero_o (ref_zero)
    );

    // Operand capture on the accepting edge only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dco_q      <= '0;
            ref_q      <= '0;
            ref_zero_q <= 1'b0;
        end else if (state_q == ST_IDLE && start_i) begin
            dco_q      <= dco_mhz_i;
            ref_q      <= ref_eff;
            ref_zero_q <= ref_zero;
        end
    end

    always_comb begin
        num_khz  = NUM_W'(dco_q) * NUM_W'(SCALE_KHZ);
        dividend = {num_khz, {FRAC_W{1'b0}}};
    end

    dco_restoring_div #(
        .DVD_W (DVD_W),
        .DVS_W (REF_W)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (div_load),
        .step_i     (div_step),
        .dividend_i (dividend),
        .divisor_i  (ref_q),
        .quot_o     (quot),
        .rem_o      (rem),
        .last_o     (div_last)
    );

    dco_round_pack #(
        .DVD_W  (DVD_W),
        .DVS_W  (REF_W),
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_pack (
        .quot_i     (quot),
        .rem_i      (rem),
        .div_zero_i (ref_zero_q),
        .int_o      (int_n),
        .frac_o     (frac_n),
        .word_o     (word_n)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_DIVIDE;
            ST_DIVIDE: if (div_last) state_d = ST_ROUND;
            ST_ROUND:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result registers: written once per computation, held otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q  <= '0;
            frac_q <= '0;
            word_q <= '0;
        end else if (state_q == ST_ROUND) begin
            int_q  <= int_n;
            frac_q <= frac_n;
            word_q <= word_n;
        end
    end

    // Output and control decode.
    always_comb begin
        div_load = (state_q == ST_LOAD);
        div_step = (state_q == ST_DIVIDE);
        done_o   = (state_q == ST_FINISH);
        int_o    = int_q;
        frac_o   = frac_q;
        word_o   = word_q;
    end

endmodule

// File: rtl/dco_word_calc_chk.sv
module dco_word_calc_chk
    import dco_calc_pkg::*;
#(
    parameter int unsigned REF_W     = 17,
    parameter int unsigned INT_W     = 10,
    parameter int unsigned FRAC_W    = 15,
    parameter int unsigned DVD_W     = 40,
    parameter int unsigned HALVE_KHZ = 38400
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic [REF_W-1:0]        ref_khz_i,
    input logic                    done_o,
    input logic [INT_W-1:0]        int_o,
    input logic [FRAC_W-1:0]       frac_o,
    input logic [INT_W+FRAC_W-1:0] word_o,
    input calc_state_e             state_q,
    input logic [REF_W-1:0]        ref_q,
    input logic                    ref_zero_q,
    input logic                    div_last
);
    localparam int unsigned LAT   = DVD_W + 2;
    localparam int unsigned LAT_W = $clog2(LAT + 2) + 1;

    logic [LAT_W-1:0] lat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (state_q == ST_IDLE) begin
            lat_cnt <= '0;
        end else begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    // R7: single-cycle done pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: done arrives a fixed number of edges after acceptance
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_cnt == LAT_W'(LAT)));

    // R7: the last divider step leads into rounding
    a_r7_last_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIVIDE && div_last) |=> (state_q == ST_ROUND));

    // R8: start while busy never restarts the sequence
    a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> (state_q != ST_LOAD));

    // R5: the special reference is halved at capture
    a_r5_halve: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && ref_khz_i == REF_W'(HALVE_KHZ))
        |=> (ref_q == REF_W'(HALVE_KHZ / 2)));

    // R5: other references pass unchanged
    a_r5_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && ref_khz_i != REF_W'(HALVE_KHZ))
        |=> (ref_q == $past(ref_khz_i)));

    // R9: zero reference saturates both fields
    a_r9_zero_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ref_zero_q) |-> (int_o == '1 && frac_o == '1));

    // R10: results change only together with done
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_o) |-> done_o);

endmodule

bind dco_word_calc dco_word_calc_chk #(
    .REF_W     (REF_W),
    .INT_W     (INT_W),
    .FRAC_W    (FRAC_W),
    .DVD_W     (DVD_W),
    .HALVE_KHZ (HALVE_KHZ)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ref_khz_i  (ref_khz_i),
    .done_o     (done_o),
    .int_o      (int_o),
    .frac_o     (frac_o),
    .word_o     (word_o),
    .state_q    (state_q),
    .ref_q      (ref_q),
    .ref_zero_q (ref_zero_q),
    .div_last   (div_last)
);

// File: tb/sim_dco_word_calc.sv
`timescale 1ns/1ps
module sim_dco_word_calc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [14:0] dco = '0;
    logic [16:0] rfk = '0;
    logic        done;
    logic [9:0]  iv;
    logic [14:0] fv;
    logic [24:0] wv;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dco_word_calc u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .dco_mhz_i (dco),
        .ref_khz_i (rfk),
        .done_o    (done),
        .int_o     (iv),
        .frac_o    (fv),
        .word_o    (wv)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model(input longint d, input longint r_in,
                                  output longint ei, output longint ef);
        longint r, n, q;
        r = (r_in == 38400) ? 19200 : r_in;
        if (r == 0) begin
            ei = 1023;
            ef = 32767;
        end else begin
            n = d * 1000 * 32768;
            q = n / r;
            if ((n % r) != 0) q = q + 1;
            ei = (q >> 15) & 1023;
            ef = q & 32767;
        end
    endfunction

    // Accept a start, count edges to done, check fields, packing and pulse width.
    task automatic run_case(input longint d, input longint r, input string req);
        longint ei, ef;
        int cyc;
        model(d, r, ei, ef);
        @(negedge clk);
        dco = 15'(d);
        rfk = 17'(r);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        cyc = 0;
        while (done !== 1'b1 && cyc < 100) begin
            @(posedge clk);
            #1;
            cyc++;
        end
        chk("R7 latency", cyc, 42);
        chk({req, " int"}, iv, ei);
        chk({req, " frac"}, fv, ef);
        chk("R6 word int field", wv[9:0], ei);
        chk("R6 word frac field", wv[24:10], ef);
        @(posedge clk);
        #1 chk("R7 done width", done, 0);
    endtask

    task automatic t_reset;
        chk("R1 done", done, 0);
        chk("R1 int", iv, 0);
        chk("R1 frac", fv, 0);
        chk("R1 word", wv, 0);
    endtask

    task automatic t_exact;
        // 8100 MHz / 24000 kHz = 337.5 exactly: no rounding
        run_case(8100, 24000, "R3 exact");
        chk("R3 exact frac value", fv, 16384);
        chk("R2 exact int value", iv, 337);
    endtask

    task automatic t_round;
        run_case(8090, 19200, "R2 round");
        run_case(9000, 24000, "R3 round");
        run_case(7998, 27000, "R3 round2");
    endtask

    task automatic t_halve;
        logic [9:0]  i_half;
        logic [14:0] f_half;
        run_case(8090, 38400, "R5 halved");
        i_half = iv;
        f_half = fv;
        run_case(8090, 19200, "R5 ref19200");
        chk("R5 same int as 19200", i_half, iv);
        chk("R5 same frac as 19200", f_half, fv);
        run_case(8090, 38401, "R5 not halved");
    endtask

    task automatic t_wrap;
        // 100 MHz / 100001 kHz: truncated fraction is 32767, rounding carries
        run_case(100, 100001, "R4 wrap");
        chk("R4 wrap int", iv, 1);
        chk("R4 wrap frac", fv, 0);
    endtask

    task automatic t_trunc;
        run_case(30000, 1000, "R2 trunc");
        chk("R2 trunc int value", iv, 30000 % 1024);
    endtask

    task automatic t_zero;
        run_case(8000, 0, "R9 zero ref");
        chk("R9 int ones", iv, 1023);
        chk("R9 frac ones", fv, 32767);
    endtask

    task automatic t_busy;
        longint ei, ef;
        int cyc;
        bit extra;
        model(8500, 24000, ei, ef);
        @(negedge clk);
        dco = 15'd8500;
        rfk = 17'd24000;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        cyc = 0;
        repeat (10) begin @(posedge clk); #1; cyc++; end
        dco = 15'd1234;
        rfk = 17'd38400;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        cyc++;
        while (done !== 1'b1 && cyc < 100) begin
            @(posedge clk);
            #1;
            cyc++;
        end
        chk("R8 latency from first start", cyc, 42);
        chk("R8 int from first operands", iv, ei);
        chk("R8 frac from first operands", fv, ef);
        extra = 1'b0;
        repeat (60) begin
            @(posedge clk);
            #1;
            if (done) extra = 1'b1;
        end
        chk("R8 no second run", extra, 0);
    endtask

    task automatic t_hold;
        logic [24:0] w0;
        bit seen;
        run_case(9999, 25000, "R10 setup");
        w0 = wv;
        seen = 1'b0;
        dco = 15'd123;
        rfk = 17'd777;
        repeat (20) begin
            @(posedge clk);
            #1;
            if (done) seen = 1'b1;
        end
        chk("R10 word held", wv, w0);
        chk("R10 no done while idle", seen, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        t_exact();
        t_round();
        t_halve();
        t_wrap();
        t_trunc();
        t_zero();
        t_busy();
        t_hold();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule